// File: doc/BRIEF.md
# Single-Channel DMA Engine

This block moves a programmed block of data between one peripheral and system memory, so the CPU does not have to handle each word. Software writes a starting memory address, a unit count and a control word through a small register port. Writing the control word with its start bit set launches the transfer.

The engine then asks the CPU for the system bus with a request/grant handshake. While it owns the bus, it moves one unit in each cycle in which the peripheral asks for service. In that cycle it drives the memory address and a read or write strobe, routes the data between the two sides and pulses an acknowledge to the peripheral.

A mode bit picks how long the bus is held. Burst mode keeps the bus for the whole block. Cycle-stealing mode hands the bus back after every unit and asks for it again. When the last unit has moved and the bus has been returned, a sticky interrupt flag is raised.

Memory is modelled as single-cycle: write data is taken, and read data is returned, in the strobe cycle.

Top module: `dma_engine`

## Requirements
- R1: After reset, `br`, `irq`, `mem_rd`, `mem_wr` and `per_ack` are low, and all four registers read as zero.
- R2: The register map is as follows. Offset 0 is the current memory address. Offset 1 is the remaining unit count. Offset 2 is the control word: bit 0 is start (write-only, reads 0), bit 1 is direction (0 = peripheral to memory, 1 = memory to peripheral), bits 3:2 are the log2 of the unit size in bytes, and bit 4 is the mode (0 = burst, 1 = cycle-stealing). Offset 3 is the status word: bit 0 is busy and bit 1 is the interrupt flag.
- R3: Starting with a nonzero count raises `br`. No memory strobe appears unless `br` and `bg` are both high.
- R4: With direction 0, a unit is a `mem_wr` cycle in which `mem_wdata` equals `per_rdata`. With direction 1, a unit is a `mem_rd` cycle in which `per_wdata` equals `mem_rdata`.
- R5: A unit moves only in a cycle in which `per_req` and `bg` are both high, and `per_ack` is high in exactly that cycle.
- R6: In burst mode, `br` stays high from grant until the last unit, and is low in the cycle after the last unit.
- R7: In cycle-stealing mode, `br` is low in the cycle after every unit, and is raised again while units remain.
- R8: After `br` falls, it is not raised again until `bg` has been seen low.
- R9: After each unit, the address register advances by 2^size, wrapping at the address width, and the count register drops by one.
- R10: The interrupt flag is set once the last unit has moved and `bg` is low. It holds until status is written with bit 1 set. If the flag is being set and cleared in the same cycle, the set takes effect.
- R11: Starting with a count of zero raises the interrupt flag at once, without ever raising `br`.
- R12: While busy, writes to the address, count and control registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for write and read |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| irq | output | 1 | Block-complete interrupt flag |
| br | output | 1 | Bus request to the CPU |
| bg | input | 1 | Bus grant from the CPU |
| mem_addr | output | AW | Memory address of the current unit |
| mem_size | output | 2 | Log2 of the unit size in bytes |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Data written to memory |
| mem_rdata | input | DW | Data read from memory |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Peripheral acknowledge, high while a unit moves |
| per_rdata | input | DW | Data from the peripheral |
| per_wdata | output | DW | Data to the peripheral |

## Verification
Two events can land on the same clock edge: the completion event that sets the interrupt flag, and a CPU status write that clears it. The bench provokes this with a one-unit burst. It drops `bg` and writes the clear bit in the same cycle, so the engine sees the bus returned and the clear at one edge. The flag must read high afterwards, and a later clear on its own must bring it low.

// File: rtl/dma_pkg.sv
// Package: shared types and register offsets for the DMA engine.
// Assumes a 2-bit register offset and a 2-bit unit-size field.
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,    // no transfer in progress
        ST_REQ,     // bus requested, waiting for grant
        ST_XFER,    // bus owned, moving units
        ST_REL      // request dropped, waiting for grant to fall
    } xfer_state_t;

    localparam logic [1:0] RA_ADDR  = 2'd0;
    localparam logic [1:0] RA_COUNT = 2'd1;
    localparam logic [1:0] RA_CTRL  = 2'd2;
    localparam logic [1:0] RA_STAT  = 2'd3;

    localparam int CB_START = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_SZ    = 2;
    localparam int CB_STEAL = 4;
    localparam int SB_BUSY  = 0;
    localparam int SB_IRQ   = 1;

    typedef struct packed {
        logic       steal;   // 1: give the bus back after each unit
        logic [1:0] size;    // log2 of bytes per unit
        logic       dir;     // 1: memory to peripheral
    } ctrl_t;
endpackage

// File: rtl/dma_regs.sv
// Module: dma_regs
// Holds the CPU-visible address, count, control and interrupt state.
// Updates address and count once per moved unit. Ignores writes to
// the address, count and control registers while a transfer is busy.
// Assumes DW is wide enough for the address and count fields.
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [1:0]    rsel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic          unit_done,
    input  logic          blk_done,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output ctrl_t         ctrl,
    output logic          go,
    output logic          irq
);
    logic          wr_ok;
    logic          clr_req;
    logic [AW-1:0] step;
    logic          unused_wbits;

    assign wr_ok        = wr && !busy;
    assign clr_req      = wr && (rsel == RA_STAT) && wdata[SB_IRQ];
    assign go           = wr_ok && (rsel == RA_CTRL) && wdata[CB_START];
    assign step         = AW'(1) << ctrl.size;
    assign unused_wbits = ^wdata;

    // Address register: loaded by the CPU when idle, advanced per unit.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cur_addr <= '0;
        else if (wr_ok && rsel == RA_ADDR)       cur_addr <= wdata[AW-1:0];
        else if (unit_done)                      cur_addr <= cur_addr + step;
    end

    // Count register: loaded by the CPU when idle, decremented per unit.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cur_cnt <= '0;
        else if (wr_ok && rsel == RA_COUNT)      cur_cnt <= wdata[CW-1:0];
        else if (unit_done)                      cur_cnt <= cur_cnt - CW'(1);
    end

    // Control fields: captured on any idle write to the control offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl <= '0;
        else if (wr_ok && rsel == RA_CTRL)
            ctrl <= '{steal: wdata[CB_STEAL], size: wdata[CB_SZ +: 2],
                      dir: wdata[CB_DIR]};
    end

    // Interrupt flag: completion sets it, and wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq <= 1'b0;
        else if (blk_done)   irq <= 1'b1;
        else if (clr_req)    irq <= 1'b0;
    end

    // Read multiplexer for the register port.
    always_comb begin
        rdata = '0;
        case (rsel)
            RA_ADDR:  rdata = DW'(cur_addr);
            RA_COUNT: rdata = DW'(cur_cnt);
            RA_CTRL:  rdata = DW'({ctrl, 1'b0});
            RA_STAT:  rdata = DW'({irq, busy});
            default:  rdata = '0;
        endcase
    end

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |=> cur_cnt == $past(cur_cnt) - CW'(1));
    // R12
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && rsel == RA_COUNT && !unit_done) |=> cur_cnt == $past(cur_cnt));
    // R10
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> irq);
endmodule

// File: rtl/dma_bus_fsm.sv
// Module: dma_bus_fsm
// Sequences bus ownership with a request/grant handshake and moves one
// unit per cycle in which the peripheral requests and the grant is held.
// Assumes the grant only rises in answer to a request.
module dma_bus_fsm
    import dma_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [CW-1:0] cnt,
    input  logic          steal,
    input  logic          dir,
    input  logic          bg,
    input  logic          per_req,
    output logic          br,
    output logic          per_ack,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          unit_done,
    output logic          blk_done,
    output logic          busy
);
    xfer_state_t state, state_nx;
    logic        move;
    logic        last;

    assign move      = (state == ST_XFER) && bg && per_req;
    assign last      = (cnt == CW'(1));
    assign br        = (state == ST_REQ) || (state == ST_XFER);
    assign per_ack   = move;
    assign mem_wr    = move && !dir;
    assign mem_rd    = move && dir;
    assign unit_done = move;
    assign busy      = (state != ST_IDLE);
    assign blk_done  = ((state == ST_IDLE) && go && cnt == '0) ||
                       ((state == ST_REL) && !bg && cnt == '0);

    // Next-state selection for the bus handshake.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (go && cnt != '0)          state_nx = ST_REQ;
            ST_REQ:  if (bg)                       state_nx = ST_XFER;
            ST_XFER: if (move && (last || steal))  state_nx = ST_REL;
            ST_REL:  if (!bg) state_nx = (cnt == '0) ? ST_IDLE : ST_REQ;
            default:                               state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R8
    br_rerequest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(br) |-> !$past(bg));
    // R7
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && steal) |=> !br);
    // R6
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && !steal && cnt > CW'(1)) |=> br);
    // R11
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt == '0) |=> (!br && !busy));
endmodule

// File: rtl/dma_engine.sv
// Module: dma_engine (top)
// Single-channel DMA engine: register block plus bus sequencer, with
// the data path routed combinationally between peripheral and memory.
// Assumes memory completes each access in the strobe cycle.
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          br,
    input  logic          bg,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          per_req,
    output logic          per_ack,
    input  logic [DW-1:0] per_rdata,
    output logic [DW-1:0] per_wdata
);
    ctrl_t         ctrl;
    logic [CW-1:0] cur_cnt;
    logic          go, busy, unit_done, blk_done;

    dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rsel(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
        .unit_done(unit_done), .blk_done(blk_done), .cur_addr(mem_addr),
        .cur_cnt(cur_cnt), .ctrl(ctrl), .go(go), .irq(irq)
    );

    dma_bus_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .cnt(cur_cnt),
        .steal(ctrl.steal), .dir(ctrl.dir), .bg(bg), .per_req(per_req),
        .br(br), .per_ack(per_ack), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .unit_done(unit_done), .blk_done(blk_done), .busy(busy)
    );

    assign mem_size  = ctrl.size;
    assign mem_wdata = mem_wr ? per_rdata : '0;
    assign per_wdata = mem_rd ? mem_rdata : '0;

    // R3
    strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (br && bg));
    // R5
    ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> (per_req && bg));
endmodule

// File: tb/test_dma_engine.sv
`timescale 1ns/1ps
module test_dma_engine;
    localparam int AW = 16, CW = 12, DW = 32;

    typedef struct packed {
        logic       dir;
        logic [1:0] size;
        logic       steal;
        logic [7:0] cnt;
        logic [15:0] addr;
        logic [7:0] pat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 8'd4, 16'h0100, 8'hFF},
        '{1'b1, 2'd2, 1'b0, 8'd3, 16'h2000, 8'b1011_0110},
        '{1'b0, 2'd1, 1'b1, 8'd3, 16'h0300, 8'hFF},
        '{1'b1, 2'd0, 1'b1, 8'd5, 16'hFFFE, 8'b1110_1101},
        '{1'b0, 2'd3, 1'b0, 8'd2, 16'h1008, 8'h55},
        '{1'b1, 2'd1, 1'b1, 8'd1, 16'h4444, 8'hFF}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic irq, br, bg = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_size;
    logic mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata, mem_rdata = '0;
    logic per_req = 1'b0, per_ack;
    logic [DW-1:0] per_rdata = '0, per_wdata;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    dma_engine #(.AW(AW), .CW(CW), .DW(DW)) i_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .br(br),
        .bg(bg), .mem_addr(mem_addr), .mem_size(mem_size), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_req(per_req), .per_ack(per_ack), .per_rdata(per_rdata),
        .per_wdata(per_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic run_vec(input int vi, input vec_t v);
        logic [15:0] exp_addr;
        logic [31:0] rd;
        logic last_br, prev_bg, prev_strobe, strobe;
        int units;
        bit done;
        exp_addr = v.addr; units = 0; done = 0;
        last_br = 1'b0; prev_bg = 1'b0; prev_strobe = 1'b0;
        wr_reg(2'd0, 32'(v.addr));
        wr_reg(2'd1, 32'(v.cnt));
        wr_reg(2'd2, {27'd0, v.steal, v.size, v.dir, 1'b1});
        for (int c = 0; c < 600 && !done; c++) begin
            @(negedge clk);
            bg = last_br;
            per_req = v.pat[c % 8];
            per_rdata = {8'hA5, 8'(vi), 16'(c)};
            mem_rdata = {8'h5A, 8'(vi), 16'(c)};
            reg_addr = 2'd3;
            #1;
            strobe = mem_rd | mem_wr;
            // R8: a new request only after the grant was seen low
            if (br && !last_br) chk("R8 br rise after bg low", 32'(prev_bg), 32'd0);
            if (prev_strobe) begin
                if (units == int'(v.cnt)) chk("R6/R7 br low after last unit", 32'(br), 32'd0);
                else if (v.steal) chk("R7 br dropped after unit", 32'(br), 32'd0);
                else chk("R6 br held in burst", 32'(br), 32'd1);
            end
            if (strobe) begin
                chk("R3 strobe under grant", 32'(bg & br), 32'd1);
                chk("R5 ack with req", 32'({per_ack, per_req}), 32'd3);
                chk("R9 address", 32'(mem_addr), 32'(exp_addr));
                if (v.dir) chk("R4 mem to periph", per_wdata, mem_rdata);
                else       chk("R4 periph to mem", mem_wdata, per_rdata);
                chk("R4 strobe kind", 32'({mem_rd, mem_wr}), v.dir ? 32'd2 : 32'd1);
                exp_addr = exp_addr + (16'd1 << v.size);
                units++;
            end else if (!per_req) begin
                chk("R5 no ack without req", 32'(per_ack), 32'd0);
            end
            last_br = br; prev_bg = bg; prev_strobe = strobe;
            if (units == int'(v.cnt) && reg_rdata[0] == 1'b0) done = 1;
        end
        chk("R10 block completed", 32'(done), 32'd1);
        chk("R10 irq raised", 32'(irq), 32'd1);
        bg = 1'b0; per_req = 1'b0;
        rd_reg(2'd0, rd); chk("R9 final address", rd, 32'(exp_addr));
        rd_reg(2'd1, rd); chk("R9 final count", rd, 32'd0);
        rd_reg(2'd2, rd); chk("R2 control readback", rd, {27'd0, v.steal, v.size, v.dir, 1'b0});
        chk("R2 size output", 32'(mem_size), 32'(v.size));
        wr_reg(2'd3, 32'h2); #1;
        chk("R10 irq cleared", 32'(irq), 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 outputs idle", 32'({br, irq, mem_rd, mem_wr, per_ack}), 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), rd); chk("R1 register zero", rd, 32'd0);
        end

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

        // R11: zero count finishes without the bus
        wr_reg(2'd1, 32'd0);
        wr_reg(2'd2, 32'h1); #1;
        chk("R11 irq at once", 32'(irq), 32'd1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk("R11 no bus request", 32'(br), 32'd0);
        end
        rd_reg(2'd3, rd); chk("R11 not busy", 32'(rd[0]), 32'd0);
        wr_reg(2'd3, 32'h2);

        // R12: writes while busy are ignored
        wr_reg(2'd0, 32'h0800);
        wr_reg(2'd1, 32'd2);
        wr_reg(2'd2, 32'h1);
        wr_reg(2'd0, 32'h1234);
        wr_reg(2'd1, 32'd9);
        wr_reg(2'd2, 32'h1E);
        rd_reg(2'd0, rd); chk("R12 address kept", rd, 32'h0800);
        rd_reg(2'd1, rd); chk("R12 count kept", rd, 32'd2);
        rd_reg(2'd2, rd); chk("R12 control kept", rd, 32'd0);
        rd_reg(2'd3, rd); chk("R2 busy bit", 32'(rd[0]), 32'd1);
        chk("R3 request before grant", 32'({br, mem_wr}), 32'd2);
        @(negedge clk); bg = 1'b1; per_req = 1'b1;
        repeat (4) @(negedge clk);
        bg = 1'b0; per_req = 1'b0;
        repeat (2) @(negedge clk);
        rd_reg(2'd0, rd); chk("R12 two units only", rd, 32'h0802);
        chk("R12 irq after block", 32'(irq), 32'd1);
        wr_reg(2'd3, 32'h2);

        // R10: completion and clear collide in one cycle
        wr_reg(2'd0, 32'h0040);
        wr_reg(2'd1, 32'd1);
        wr_reg(2'd2, 32'h1);
        bg = 1'b1; per_req = 1'b1;
        @(negedge clk); #1;
        chk("R4 single unit write", 32'(mem_wr), 32'd1);
        @(negedge clk);
        per_req = 1'b0; bg = 1'b0;
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h2;
        #1; chk("R10 irq before collision", 32'(irq), 32'd0);
        @(negedge clk); reg_wr = 1'b0; #1;
        chk("R10 set wins over clear", 32'(irq), 32'd1);
        wr_reg(2'd3, 32'h2); #1;
        chk("R10 later clear", 32'(irq), 32'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule